// File: doc/BRIEF.md
# Per-Stream Input Frame Offset Aligner

This block sits in front of the data memory of a time-division switch that takes several serial input streams. Backplane traces of unequal length make each stream arrive late by a different amount. The block shifts the bit and channel alignment of every stream, independently, to a later point relative to the shared frame pulse. The output frame reference itself never moves.

The block runs on a clock at twice the master bit-clock rate, so one clock cycle is one half master period. A serial bit is held for two cycles, and the first bit of a frame starts in the cycle where `frame_pulse` is high.

Each stream has a 4-bit offset code, written through a one-cycle write strobe. The block delays the stream's data and its own copy of the frame pulse by that many half periods. A new code is held back until the next frame pulse, so no frame is partly aligned. For every stream, the block delivers a re-timed bit with a strobe, a bit index and a channel index. Its counters restart on the delayed frame position. A per-channel loopback further downstream works only for streams whose offset is programmed to zero.

Top module: `frame_offset_aligner`

## Requirements
- R1: Each stream has its own offset register, selected by `cfg_sel`. A write to one stream leaves the timing of every other stream unchanged.
- R2: Let the effective code of a stream be n, in the range 0 to 8. The strobe for frame bit m (m counts from 0 at the frame start) is registered at the clock edge n+2m+1 edges after the edge that samples `frame_pulse`. Each code step therefore moves the stream by one cycle, which is half a master period.
- R3: The codes 9 to 15 act exactly like code 8, the largest delay.
- R4: A written code takes effect at the edge that samples the next `frame_pulse`. Bits of the current frame keep the old offset until that edge.
- R5: Counters restart on the delayed frame position. The strobe for frame bit m carries `rt_bitno` = m mod 8 and `rt_chan` = m div 8. The strobe is never high in two consecutive cycles.
- R6: `rt_bit` equals the value the stream carried in the second cycle of that bit.
- R7: While `rst_n` is low, and in the first cycle after it, all strobes and re-timed bits are 0 and all effective codes are 0.
- R8: A stream strobes only from its delayed frame position until the last bit of that frame. With no further frame pulse it then stays silent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the master bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_pulse | input | 1 | One-cycle frame start marker, output reference |
| ser_in | input | NUM_STREAMS | Raw serial inputs, one bit per stream |
| cfg_we | input | 1 | Offset register write strobe |
| cfg_sel | input | SEL_W | Stream index for the write |
| cfg_code | input | 4 | Offset code in half master periods |
| rt_bit | output | NUM_STREAMS | Re-timed data bit per stream |
| rt_strobe | output | NUM_STREAMS | Bit valid strobe per stream |
| rt_bitno | output | 3*NUM_STREAMS | Bit index inside the channel, per stream |
| rt_chan | output | CH_W*NUM_STREAMS | Channel index, per stream |

## Verification
Four streams run with distinct offsets at the same time: 0, 1, 5 and 8 half periods. Strobe times that differ by a single cycle between neighbouring codes show the half-period step, and they separate a per-stream delay from a shared one. Frames cycle through three data patterns: an alternating bit sequence, a per-channel code and a hashed sequence. These expose a sample taken one cycle early or late, and a bit or channel index that is off by one. Codes are rewritten in the middle of a frame, with values above 8, with shrinking and growing delays, and on a single stream only. This separates a boundary-synchronous update from an immediate one and confirms the saturation. A final stretch with no frame pulse shows that the lanes fall silent.

// File: rtl/ofa_pkg.sv
// Shared constants and helpers for the frame offset aligner.
// Assumes one clock cycle equals one half master period.
package ofa_pkg;
    localparam int CODE_W       = 4;
    localparam int MAX_HALF     = 8;
    localparam int BITS_PER_CH  = 8;
    localparam int CYC_PER_BIT  = 2;

    // Limit a raw offset code to the largest supported delay.
    function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] raw);
        return (raw > CODE_W'(MAX_HALF)) ? CODE_W'(MAX_HALF) : raw;
    endfunction
endpackage

// File: rtl/ofa_cfg_bank.sv
// Per-stream offset registers: a pending copy written by the host and an
// active copy loaded on the raw frame pulse.
// Assumes writes do not coincide with frame_pulse.
// The effective code follows the pending value in the frame pulse cycle itself.
module ofa_cfg_bank
    import ofa_pkg::*;
#(
    parameter int NUM_STREAMS = 4,
    parameter int SEL_W       = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          frame_pulse,
    input  logic                          cfg_we,
    input  logic [SEL_W-1:0]              cfg_sel,
    input  logic [CODE_W-1:0]             cfg_code,
    output logic [NUM_STREAMS*CODE_W-1:0] eff_code
);
    for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_reg
        logic [CODE_W-1:0] pend_q;
        logic [CODE_W-1:0] act_q;

        // Capture a host write, already clamped.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= '0;
            end else if (cfg_we && (cfg_sel == SEL_W'(i))) begin
                pend_q <= clamp_code(cfg_code);
            end
        end

        // Promote the pending code at the frame boundary.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_q <= '0;
            end else if (frame_pulse) begin
                act_q <= pend_q;
            end
        end

        // New frame uses the new code from its first cycle.
        always_comb begin
            eff_code[i*CODE_W +: CODE_W] = frame_pulse ? pend_q : act_q;
        end
    end
endmodule

// File: rtl/ofa_delay_tap.sv
// Delay line of half-period stages for one stream's data and frame marker.
// Assumes sel never exceeds MAX_HALF; a tap of zero passes the input through.
module ofa_delay_tap
    import ofa_pkg::*;
#(
    parameter int DEPTH = MAX_HALF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic              fin,
    input  logic [CODE_W-1:0] sel,
    output logic              dout,
    output logic              fout
);
    logic [DEPTH-1:0] dl_q;
    logic [DEPTH-1:0] fl_q;

    // Shift raw data and marker one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dl_q <= '0;
            fl_q <= '0;
        end else begin
            dl_q <= {dl_q[DEPTH-2:0], din};
            fl_q <= {fl_q[DEPTH-2:0], fin};
        end
    end

    // Pick the stage that matches the selected delay.
    always_comb begin
        dout = din;
        fout = fin;
        for (int j = 1; j <= DEPTH; j++) begin
            if (sel == CODE_W'(j)) begin
                dout = dl_q[j-1];
                fout = fl_q[j-1];
            end
        end
    end
endmodule

// File: rtl/ofa_lane_count.sv
// Position counter and output register for one stream.
// It restarts on the delayed frame marker and stops after the last bit.
// Assumes CHANNELS is a power of two; a bit spans two cycles and is sampled in the second.
module ofa_lane_count
    import ofa_pkg::*;
#(
    parameter int CHANNELS = 32,
    parameter int CH_W     = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mark,
    input  logic            din,
    output logic            strobe,
    output logic            bit_out,
    output logic [2:0]      bitno,
    output logic [CH_W-1:0] chan
);
    localparam int FRAME_LEN = CHANNELS * BITS_PER_CH * CYC_PER_BIT;
    localparam int CNT_W     = $clog2(FRAME_LEN);

    logic [CNT_W-1:0] cnt_q;
    logic             locked_q;
    logic [CNT_W-1:0] pos;

    // Position within the delayed frame; zero on the marker itself.
    always_comb begin
        pos = mark ? '0 : cnt_q;
    end

    // Advance the position, relock on a marker, release after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            locked_q <= 1'b0;
        end else if (mark) begin
            cnt_q    <= CNT_W'(1);
            locked_q <= 1'b1;
        end else if (locked_q) begin
            if (cnt_q == CNT_W'(FRAME_LEN - 1)) begin
                cnt_q    <= '0;
                locked_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // Register the sampled bit and its indices in the second cycle of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe  <= 1'b0;
            bit_out <= 1'b0;
            bitno   <= '0;
            chan    <= '0;
        end else begin
            strobe <= locked_q && !mark && pos[0];
            if (locked_q && !mark && pos[0]) begin
                bit_out <= din;
                bitno   <= pos[3:1];
                chan    <= pos[CNT_W-1:4];
            end
        end
    end
endmodule

// File: rtl/frame_offset_aligner.sv
// Top of the per-stream input frame offset aligner.
// Each stream gets a programmable delay in half master periods.
// Assumes clk runs at twice the master rate and frame_pulse lasts one cycle.
module frame_offset_aligner
    import ofa_pkg::*;
#(
    parameter int NUM_STREAMS = 4,
    parameter int CHANNELS    = 32,
    localparam int SEL_W      = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
    localparam int CH_W       = $clog2(CHANNELS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_pulse,
    input  logic [NUM_STREAMS-1:0]      ser_in,
    input  logic                        cfg_we,
    input  logic [SEL_W-1:0]            cfg_sel,
    input  logic [3:0]                  cfg_code,
    output logic [NUM_STREAMS-1:0]      rt_bit,
    output logic [NUM_STREAMS-1:0]      rt_strobe,
    output logic [3*NUM_STREAMS-1:0]    rt_bitno,
    output logic [CH_W*NUM_STREAMS-1:0] rt_chan
);
    logic [NUM_STREAMS*CODE_W-1:0] eff_v;
    logic [NUM_STREAMS-1:0]        mark_v;
    logic [NUM_STREAMS-1:0]        dly_v;

    ofa_cfg_bank #(
        .NUM_STREAMS(NUM_STREAMS),
        .SEL_W      (SEL_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_pulse(frame_pulse),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_code   (cfg_code),
        .eff_code   (eff_v)
    );

    for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_lane
        ofa_delay_tap #(
            .DEPTH(MAX_HALF)
        ) u_tap (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (ser_in[i]),
            .fin  (frame_pulse),
            .sel  (eff_v[i*CODE_W +: CODE_W]),
            .dout (dly_v[i]),
            .fout (mark_v[i])
        );

        ofa_lane_count #(
            .CHANNELS(CHANNELS),
            .CH_W    (CH_W)
        ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .mark   (mark_v[i]),
            .din    (dly_v[i]),
            .strobe (rt_strobe[i]),
            .bit_out(rt_bit[i]),
            .bitno  (rt_bitno[i*3 +: 3]),
            .chan   (rt_chan[i*CH_W +: CH_W])
        );
    end
endmodule

// File: rtl/ofa_chk.sv
// Property checker for frame_offset_aligner, attached through bind.
// Observes ports plus the effective codes and delayed markers.
module ofa_chk #(
    parameter int NS   = 4,
    parameter int CH_W = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_pulse,
    input logic [NS-1:0]        rt_strobe,
    input logic [3*NS-1:0]      rt_bitno,
    input logic [CH_W*NS-1:0]   rt_chan,
    input logic [NS-1:0]        mark_v,
    input logic [NS*4-1:0]      eff_v
);
    // R7: reset clears every strobe by the next edge.
    a_r7_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (rt_strobe == '0));

    // R4: effective codes move only at a frame pulse.
    a_r4_code_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_pulse |-> $stable(eff_v));

    for (genvar i = 0; i < NS; i++) begin : g_p
        // R3: effective code never above eight half periods.
        a_r3_code_capped: assert property (@(posedge clk) disable iff (!rst_n)
            eff_v[i*4 +: 4] <= 4'd8);

        // R5: strobes are spaced at least two cycles apart.
        a_r5_strobe_spaced: assert property (@(posedge clk) disable iff (!rst_n)
            rt_strobe[i] |=> !rt_strobe[i]);

        // R5: a delayed frame position yields bit 0 of channel 0 next.
        a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
            mark_v[i] |=> ##1 (rt_strobe[i] && rt_bitno[i*3 +: 3] == 3'd0
                               && rt_chan[i*CH_W +: CH_W] == '0));
    end
endmodule

bind frame_offset_aligner ofa_chk #(
    .NS  (NUM_STREAMS),
    .CH_W(CH_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_pulse(frame_pulse),
    .rt_strobe  (rt_strobe),
    .rt_bitno   (rt_bitno),
    .rt_chan    (rt_chan),
    .mark_v     (mark_v),
    .eff_v      (eff_v)
);

// File: tb/sim_frame_offset_aligner.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected strobes per stream, the monitor pops and compares.
module sim_frame_offset_aligner;
    localparam int NS  = 4;
    localparam int CH  = 32;
    localparam int CHW = 5;
    localparam int F   = CH * 16;
    localparam int NFR = 7;

    typedef struct packed {
        int   t;
        int   ch;
        int   bt;
        logic v;
        int   rq;
    } item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            frame_pulse = 1'b0;
    logic [NS-1:0]   ser_in = '0;
    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_sel = '0;
    logic [3:0]      cfg_code = '0;
    logic [NS-1:0]   rt_bit;
    logic [NS-1:0]   rt_strobe;
    logic [3*NS-1:0] rt_bitno;
    logic [CHW*NS-1:0] rt_chan;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t q [NS][$];
    int    ign_lo [NS];
    int    ign_hi [NS];
    int    raw_code [NS];
    int    cur_off [NS];

    frame_offset_aligner #(.NUM_STREAMS(NS), .CHANNELS(CH)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .ser_in(ser_in),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_code(cfg_code),
        .rt_bit(rt_bit), .rt_strobe(rt_strobe), .rt_bitno(rt_bitno), .rt_chan(rt_chan)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string rq, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at cycle %0d", rq, what, act, expv, cyc);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    function automatic logic pat(input int s, input int fr, input int k);
        int c, b, h;
        c = k >> 3;
        b = k & 7;
        h = k * 37 + s * 11 + fr * 7;
        case (fr % 3)
            0:       return logic'((k + s) & 1);
            1:       return logic'(((c * 5 + s) >> b) & 1);
            default: return logic'((h ^ (h >> 3)) & 1);
        endcase
    endfunction

    function automatic int sat(input int c);
        return (c > 8) ? 8 : c;
    endfunction

    // Frame start: apply model offsets, drop stale tail items, push expectations.
    task automatic frame_start(input int fr);
        int  p;
        bit  any_chg;
        bit  chg [NS];
        item_t it;
        p = cyc + 1;
        any_chg = 1'b0;
        for (int s = 0; s < NS; s++) begin
            chg[s] = (fr > 0) && (sat(raw_code[s]) != cur_off[s]);
            if (chg[s]) any_chg = 1'b1;
        end
        for (int s = 0; s < NS; s++) begin
            if (chg[s]) begin
                while (q[s].size() > 0 && q[s][q[s].size()-1].t >= p) void'(q[s].pop_back());
                ign_lo[s] = p;
                ign_hi[s] = p + sat(raw_code[s]) - 1;
            end
            cur_off[s] = sat(raw_code[s]);
            for (int m = 0; m < F / 2; m++) begin
                it.t  = p + cur_off[s] + 2 * m + 1;
                it.ch = m / 8;
                it.bt = m % 8;
                it.v  = pat(s, fr, m);
                // R4 first frame after change, R3 saturated code, R1 neighbour rewritten, else R2
                it.rq = chg[s] ? 4 : (raw_code[s] > 8 ? 3 : (any_chg ? 1 : 2));
                q[s].push_back(it);
            end
        end
    endtask

    task automatic wr(input int s, input int code);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_sel = 2'(s);
        cfg_code = 4'(code);
        raw_code[s] = code;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Monitor: compare each strobe with the head of the stream's queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int s = 0; s < NS; s++) begin
                if (q[s].size() > 0 && q[s][0].t < cyc) begin
                    check(1'b0, "R8", "missing strobe time", -1, q[s][0].t);
                    void'(q[s].pop_front());
                end
                if (rt_strobe[s] && !(cyc >= ign_lo[s] && cyc <= ign_hi[s])) begin
                    if (q[s].size() == 0) begin
                        check(1'b0, "R8", "unexpected strobe", s, -1);
                    end else begin
                        item_t it;
                        string tg;
                        it = q[s].pop_front();
                        tg = (it.rq == 1) ? "R1" : (it.rq == 3) ? "R3" : (it.rq == 4) ? "R4" : "R2";
                        check(it.t == cyc, tg, "strobe time", cyc, it.t);
                        check(int'(rt_bitno[s*3 +: 3]) == it.bt, "R5", "bit index", int'(rt_bitno[s*3 +: 3]), it.bt);
                        check(int'(rt_chan[s*CHW +: CHW]) == it.ch, "R5", "channel index", int'(rt_chan[s*CHW +: CHW]), it.ch);
                        check(rt_bit[s] == it.v, "R6", "data bit", int'(rt_bit[s]), int'(it.v));
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", cyc, 200000);
        finish_run();
    end

    initial begin
        for (int s = 0; s < NS; s++) begin
            ign_lo[s] = 0; ign_hi[s] = -1; raw_code[s] = 0; cur_off[s] = 0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: outputs quiet right after reset
        check(rt_strobe == '0, "R7", "strobes after reset", int'(rt_strobe), 0);
        check(rt_bit == '0, "R7", "bits after reset", int'(rt_bit), 0);
        wr(0, 0); wr(1, 1); wr(2, 5); wr(3, 8);
        repeat (3) @(negedge clk);
        // R8: no strobe before any frame pulse
        check(rt_strobe == '0, "R8", "strobes before frame", int'(rt_strobe), 0);
        for (int fr = 0; fr < NFR; fr++) begin
            for (int j = 0; j < F; j++) begin
                @(negedge clk);
                if (j == 0) frame_start(fr);
                frame_pulse = (j == 0);
                for (int s = 0; s < NS; s++) ser_in[s] = pat(s, fr, j / 2);
                cfg_we = 1'b0;
                if (fr == 2 && j >= 100 && j < 104) begin
                    int s;
                    int codes [4] = '{12, 2, 0, 7};
                    s = j - 100;
                    cfg_we = 1'b1; cfg_sel = 2'(s); cfg_code = 4'(codes[s]);
                    raw_code[s] = codes[s];
                end
                if (fr == 4 && j == 200) begin
                    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_code = 4'd3;
                    raw_code[2] = 3;
                end
                if (fr == 5 && j == 150) begin
                    cfg_we = 1'b1; cfg_sel = 2'd1; cfg_code = 4'd15;
                    raw_code[1] = 15;
                end
            end
        end
        @(negedge clk);
        frame_pulse = 1'b0;
        cfg_we = 1'b0;
        ser_in = '0;
        repeat (F + 20) @(negedge clk);
        // R8: every expected strobe delivered, none pending
        for (int s = 0; s < NS; s++) check(q[s].size() == 0, "R8", "items left", q[s].size(), 0);
        check(rt_strobe == '0, "R8", "silent without frame pulse", int'(rt_strobe), 0);
        finish_run();
    end
endmodule